// File: doc/BRIEF.md
# Programmable I2C START/STOP Detector

This block watches the two lines of an I2C bus, already synchronized to the system clock, and reports each START and each STOP condition as a one-cycle pulse. A condition is reported only after it meets timing limits counted in system clock cycles. A 5-bit software count `C` sets these limits. SCL must be high for `C/2` samples before the SDA edge. SCL must stay high and SDA must stay at its new level for `C/2` samples after the edge. The limits therefore require SCL to be high for the full count `C` around the edge. A count of zero or an odd count is not a legal setting, and with such a count no condition is ever reported.

The same block also has a pin-edge interrupt source. A select bit chooses SCL or SDA, and a polarity bit chooses rising or falling edges. Each matching edge gives a one-cycle pulse and sets a sticky request. Software clears the request by writing a one to the clear input. The edge is found by comparing the current level of the selected pin with the level of the pin that was selected in the previous cycle. Changing the selection can therefore raise a request by itself. Software should clear the request after changing the selection, the polarity or the enable. While the interface enable is low, every pulse is suppressed and any condition still in its hold phase is dropped.

Top module: `bus_cond_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `start_o`, `stop_o`, `irq_pulse_o` and `irq_req_o` are all 0.
- R2: Let sample `e` be a sample where SDA goes from 1 to 0 while SCL is 1. If SCL was 1 on the `C/2` samples before `e`, and SCL=1 and SDA=0 hold on samples `e` through `e+C/2`, then `start_o` is 1 for exactly one cycle, in the cycle after sample `e+C/2`.
- R3: A STOP is qualified in the same way as a START (R2), with SDA going from 0 to 1 and staying at 1. It is reported on `stop_o`.
- R4: If SCL goes low, or SDA returns to its old level, before the `C/2` hold samples are complete, the condition is not reported.
- R5: If SCL was high on fewer than `C/2` samples before the SDA edge, the condition is not reported.
- R6: When `cond_cnt_i` is zero or odd, `start_o` and `stop_o` stay at 0.
- R7: `irq_sel_sda_i`=0 selects SCL and 1 selects SDA. `irq_rise_i`=1 selects rising edges and 0 selects falling edges. A matching edge on sample `t` gives `irq_pulse_o`=1 in the cycle after sample `t`.
- R8: `irq_req_o` is set by every interrupt pulse and then stays at 1. It is cleared by `irq_clr_i`=1. If a new edge and a clear fall on the same sample, the set wins.
- R9: While `enable_i`=0, no START, STOP or interrupt pulse is produced. If the enable drops during a hold phase, that condition is cancelled.
- R10: The edge compare uses the level of the pin that was selected in the previous sample. Switching the selection between pins that are at different levels can therefore raise an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Interface enable |
| cond_cnt_i | input | 5 | Detection count C, in system clock cycles |
| irq_sel_sda_i | input | 1 | Interrupt pin select: 0 selects SCL, 1 selects SDA |
| irq_rise_i | input | 1 | Interrupt polarity: 1 selects rising edges, 0 selects falling edges |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt request |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| start_o | output | 1 | One-cycle pulse for a qualified START |
| stop_o | output | 1 | One-cycle pulse for a qualified STOP |
| irq_pulse_o | output | 1 | One-cycle pulse for a pin-edge interrupt |
| irq_req_o | output | 1 | Sticky interrupt request |

## Verification
If the SCL high-time counter or the stored SDA level is wrong, a START or STOP pulse appears, goes missing, or comes one or more cycles off. The first sequence that crosses a setup or hold limit shows this within `C` cycles of the SDA edge. A hold counter that is stuck or off by one shifts the pulse or repeats it, so a per-cycle compare against the expected pulse cycle catches it at once. A fault in the stored pin level or in the sticky request shows at the port one cycle after the edge or clear that exposes it.

// File: rtl/bus_cond_detect_pkg.sv
package bus_cond_detect_pkg;
    parameter int CNT_W = 5;

    typedef struct packed {
        logic             sda_prev;
        logic [CNT_W-1:0] scl_high;
    } line_state_t;

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] held;
        logic             pulse;
    } qual_state_t;

    typedef struct packed {
        logic pin_prev;
        logic pulse;
        logic req;
    } irq_state_t;
endpackage

// File: rtl/bcd_line_track.sv
module bcd_line_track
    import bus_cond_detect_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_prev_o,
    output logic [CNT_W-1:0] scl_high_o
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

    line_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.sda_prev = sda_i;
        if (!scl_i)
            st_d.scl_high = '0;
        else if (st_q.scl_high != SAT)
            st_d.scl_high = st_q.scl_high + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sda_prev <= 1'b1;
            st_q.scl_high <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_prev_o = st_q.sda_prev;
    assign scl_high_o = st_q.scl_high;
endmodule

// File: rtl/bcd_cond_qual.sv
module bcd_cond_qual
    import bus_cond_detect_pkg::*;
#(
    parameter logic NEW_LEVEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             cfg_ok_i,
    input  logic [CNT_W-1:0] half_i,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             sda_prev_i,
    input  logic [CNT_W-1:0] scl_high_i,
    output logic             pulse_o
);
    qual_state_t st_d, st_q;
    logic        edge_seen;
    logic        setup_ok;

    assign edge_seen = (sda_prev_i != NEW_LEVEL) && (sda_i == NEW_LEVEL) && scl_i;
    assign setup_ok  = scl_high_i >= half_i;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!en_i) begin
            st_d.active = 1'b0;
            st_d.held   = '0;
        end else if (edge_seen && cfg_ok_i && setup_ok) begin
            st_d.active = 1'b1;
            st_d.held   = '0;
        end else if (st_q.active) begin
            if (scl_i && (sda_i == NEW_LEVEL)) begin
                if (st_q.held + 1'b1 == half_i) begin
                    st_d.pulse  = 1'b1;
                    st_d.active = 1'b0;
                    st_d.held   = '0;
                end else begin
                    st_d.held = st_q.held + 1'b1;
                end
            end else begin
                st_d.active = 1'b0;
                st_d.held   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/bcd_pin_irq.sv
module bcd_pin_irq
    import bus_cond_detect_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic sel_sda_i,
    input  logic rise_i,
    input  logic clr_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic pulse_o,
    output logic req_o
);
    irq_state_t st_d, st_q;
    logic       pin_now;
    logic       hit;

    assign pin_now = sel_sda_i ? sda_i : scl_i;
    assign hit     = rise_i ? (!st_q.pin_prev && pin_now) : (st_q.pin_prev && !pin_now);

    always_comb begin
        st_d          = st_q;
        st_d.pin_prev = pin_now;
        st_d.pulse    = en_i && hit;
        st_d.req      = st_d.pulse || (st_q.req && !clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pin_prev <= 1'b1;
            st_q.pulse    <= 1'b0;
            st_q.req      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;
    assign req_o   = st_q.req;
endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect
    import bus_cond_detect_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] cond_cnt_i,
    input  logic             irq_sel_sda_i,
    input  logic             irq_rise_i,
    input  logic             irq_clr_i,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             start_o,
    output logic             stop_o,
    output logic             irq_pulse_o,
    output logic             irq_req_o
);
    localparam int KINDS = 2;

    logic             cfg_ok;
    logic [CNT_W-1:0] half;
    logic             sda_prev;
    logic [CNT_W-1:0] scl_high;
    logic [KINDS-1:0] cond_pulse;

    assign cfg_ok = (cond_cnt_i != '0) && !cond_cnt_i[0];
    assign half   = cond_cnt_i >> 1;

    bcd_line_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_prev_o (sda_prev),
        .scl_high_o (scl_high)
    );

    for (genvar k = 0; k < KINDS; k++) begin : g_qual
        bcd_cond_qual #(.NEW_LEVEL(k[0])) u_qual (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (enable_i),
            .cfg_ok_i   (cfg_ok),
            .half_i     (half),
            .scl_i      (scl_i),
            .sda_i      (sda_i),
            .sda_prev_i (sda_prev),
            .scl_high_i (scl_high),
            .pulse_o    (cond_pulse[k])
        );
    end

    assign start_o = cond_pulse[0];
    assign stop_o  = cond_pulse[1];

    bcd_pin_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (enable_i),
        .sel_sda_i (irq_sel_sda_i),
        .rise_i    (irq_rise_i),
        .clr_i     (irq_clr_i),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .pulse_o   (irq_pulse_o),
        .req_o     (irq_req_o)
    );
endmodule

// File: rtl/bus_cond_detect_chk.sv
module bus_cond_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable_i,
    input logic [4:0] cond_cnt_i,
    input logic       irq_sel_sda_i,
    input logic       irq_rise_i,
    input logic       irq_clr_i,
    input logic       scl_i,
    input logic       sda_i,
    input logic       start_o,
    input logic       stop_o,
    input logic       irq_pulse_o,
    input logic       irq_req_o
);
    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    assert_start_scl_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(scl_i) && !$past(sda_i));
    assert_stop_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);
    assert_stop_scl_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> $past(scl_i) && $past(sda_i));
    assert_bad_count_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_cnt_i == 5'd0 || cond_cnt_i[0]) |=> !start_o && !stop_o);
    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !start_o && !stop_o && !irq_pulse_o);
    assert_pulse_sets_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse_o |-> irq_req_o);
    assert_req_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o && !irq_clr_i |=> irq_req_o);
    assert_req_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_i |=> !irq_req_o || irq_pulse_o);
    assert_req_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req_o) |-> irq_pulse_o);
endmodule

bind bus_cond_detect bus_cond_detect_chk u_chk (.*);

// File: tb/tb_bus_cond_detect.sv
module tb_bus_cond_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic [4:0] cnt = 5'd4;
    logic       sel = 1'b0;
    logic       rise = 1'b0;
    logic       clr = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       start_o, stop_o, irq_pulse_o, irq_req_o;

    int errors = 0;
    int checks = 0;
    int n_start = 0, n_stop = 0, n_irq = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bus_cond_detect dut (
        .clk(clk), .rst_n(rst_n), .enable_i(en), .cond_cnt_i(cnt),
        .irq_sel_sda_i(sel), .irq_rise_i(rise), .irq_clr_i(clr),
        .scl_i(scl), .sda_i(sda), .start_o(start_o), .stop_o(stop_o),
        .irq_pulse_o(irq_pulse_o), .irq_req_o(irq_req_o)
    );

    // behavioural history model
    localparam int HMAX = 8192;
    bit h_scl [HMAX];
    bit h_sda [HMAX];
    bit h_en  [HMAX];
    int idx = 0;
    bit e_start = 0, e_stop = 0, e_pulse = 0, e_req = 0;
    bit prev_pin = 1;

    function automatic bit g_scl(int i); return (i < 0) ? 1'b0 : h_scl[i]; endfunction
    function automatic bit g_sda(int i); return (i < 0) ? 1'b1 : h_sda[i]; endfunction
    function automatic bit g_en(int i);  return (i < 0) ? 1'b0 : h_en[i];  endfunction

    function automatic bit qualified(int t, int c, bit lvl);
        int h = c / 2;
        int e = t - h;
        if (c == 0 || (c % 2) == 1) return 1'b0;
        if (g_sda(e-1) == lvl || g_sda(e) != lvl) return 1'b0;
        for (int i = e - h; i <= t; i++) if (!g_scl(i)) return 1'b0;
        for (int i = e; i <= t; i++) if (g_sda(i) != lvl || !g_en(i)) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            e_start = 0; e_stop = 0; e_pulse = 0; e_req = 0; prev_pin = 1; idx = 0;
        end else if (idx < HMAX) begin
            bit pin, edge_hit;
            h_scl[idx] = scl; h_sda[idx] = sda; h_en[idx] = en;
            e_start = qualified(idx, int'(cnt), 1'b0);
            e_stop  = qualified(idx, int'(cnt), 1'b1);
            pin = sel ? sda : scl;
            edge_hit = rise ? (!prev_pin && pin) : (prev_pin && !pin);
            e_pulse = en && edge_hit;
            e_req = e_pulse || (e_req && !clr);
            prev_pin = pin;
            idx++;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 start_o", start_o, e_start);
            chk("R3 stop_o", stop_o, e_stop);
            chk("R7 irq_pulse_o", irq_pulse_o, e_pulse);
            chk("R8 irq_req_o", irq_req_o, e_req);
            n_start += start_o; n_stop += stop_o; n_irq += irq_pulse_o;
        end
    end

    task automatic bus(input logic c, input logic d, input int n);
        repeat (n) begin
            @(negedge clk);
            scl = c; sda = d;
        end
    endtask

    task automatic do_start(input int h);
        bus(1, 1, h + 2); bus(1, 0, h + 2); bus(0, 0, 3);
    endtask

    task automatic do_stop(input int h);
        bus(0, 0, 2); bus(1, 0, h + 2); bus(1, 1, h + 3);
    endtask

    task automatic do_clear;
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
    endtask

    initial begin
        int b;
        repeat (3) @(negedge clk);
        chk("R1 start_o in reset", start_o, 0);
        chk("R1 stop_o in reset", stop_o, 0);
        chk("R1 irq_req_o in reset", irq_req_o, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 irq_pulse_o after reset", irq_pulse_o, 0);
        bus(1, 1, 4);

        // R2/R3 basic with C=4
        cnt = 5'd4;
        b = n_start; do_start(2); chk("R2 start count C=4", n_start - b, 1);
        b = n_stop;  do_stop(2);  chk("R3 stop count C=4", n_stop - b, 1);
        // boundaries C=2 and C=30
        cnt = 5'd2;
        b = n_start; do_start(1); chk("R2 start count C=2", n_start - b, 1);
        b = n_stop;  do_stop(1);  chk("R3 stop count C=2", n_stop - b, 1);
        cnt = 5'd30;
        b = n_start; do_start(15); chk("R2 start count C=30", n_start - b, 1);
        b = n_stop;  do_stop(15);  chk("R3 stop count C=30", n_stop - b, 1);

        // R4 short hold, C=8
        cnt = 5'd8;
        bus(1, 1, 8);
        b = n_start; bus(1, 0, 3); bus(0, 0, 3);
        chk("R4 start with short hold", n_start - b, 0);
        b = n_stop; bus(1, 0, 6); bus(1, 1, 2); bus(1, 0, 8);
        chk("R4 stop with SDA bounce", n_stop - b, 0);
        bus(0, 0, 2);

        // R5 short setup, C=8
        b = n_start; bus(0, 1, 3); bus(1, 1, 2); bus(1, 0, 8); bus(0, 0, 2);
        chk("R5 start with short setup", n_start - b, 0);
        b = n_stop; bus(1, 0, 2); bus(1, 1, 8);
        chk("R5 stop with short setup", n_stop - b, 0);

        // R6 illegal counts
        cnt = 5'd5;
        b = n_start; do_start(4); chk("R6 start with odd count", n_start - b, 0);
        b = n_stop;  do_stop(4);  chk("R6 stop with odd count", n_stop - b, 0);
        cnt = 5'd0;
        b = n_start; do_start(4); chk("R6 start with zero count", n_start - b, 0);

        // R9 enable
        cnt = 5'd4;
        en = 0;
        b = n_start; do_start(2); chk("R9 start while disabled", n_start - b, 0);
        b = n_irq; bus(0, 1, 3); bus(1, 1, 3);
        chk("R9 irq while disabled", n_irq - b, 0);
        en = 1;
        cnt = 5'd8;
        bus(1, 1, 6);
        b = n_start; bus(1, 0, 2);
        @(negedge clk); en = 0;
        @(negedge clk); en = 1;
        bus(1, 0, 8); bus(0, 0, 3);
        chk("R9 hold cancelled by enable drop", n_start - b, 0);

        // R7 interrupt selection and polarity
        cnt = 5'd4;
        do_clear;
        sel = 0; rise = 0;
        bus(0, 1, 2); bus(1, 1, 3);
        b = n_irq; bus(0, 1, 3); chk("R7 SCL falling edge", n_irq - b, 1);
        rise = 1;
        b = n_irq; bus(1, 1, 3); chk("R7 SCL rising edge", n_irq - b, 1);
        sel = 1; rise = 0;
        bus(0, 1, 3);
        b = n_irq; bus(0, 0, 3); chk("R7 SDA falling edge", n_irq - b, 1);
        b = n_irq; bus(1, 0, 3); chk("R7 SDA steady, SCL toggles", n_irq - b, 0);

        // R8 sticky and clear
        @(negedge clk);
        chk("R8 request held", irq_req_o, 1);
        do_clear; @(negedge clk);
        chk("R8 request cleared", irq_req_o, 0);
        bus(0, 1, 3);
        rise = 1;
        @(negedge clk); sda = 0; clr = 0;
        @(negedge clk); sda = 1; clr = 1;
        @(negedge clk); clr = 0;
        chk("R8 set wins over clear", irq_req_o, 1);
        do_clear; bus(0, 1, 2);

        // R10 spurious edge on selection change
        sel = 0; rise = 1;
        bus(0, 1, 3);
        b = n_irq;
        @(negedge clk); sel = 1;
        bus(0, 1, 3);
        chk("R10 selection change raises edge", n_irq - b, 1);
        bus(1, 1, 4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule